// File: doc/BRIEF.md
# Indirect Coefficient RAM Loader

This block is the host-side write port of a modulator core. A narrow host bus (8 data bits, 3 address bits, active-low chip-enable, read and write strobes) reaches two internal memories that are too wide for that bus. Four byte addresses fill a 32-bit staging register. A fifth address is a command port. One command value copies the staging register's low byte into a control word. Another command value fires an internal update strobe. That strobe moves staged data into the memory selected by the control word.

In coefficient mode, three update strobes assemble a 72-bit word, 24 bits per strobe. The third strobe writes the word into both the in-phase and the quadrature coefficient RAM. In map mode, each strobe writes one byte into the symbol map RAM. The target address comes either from the top staging byte or from an internal counter that advances after every completed RAM write. Test read ports expose the three RAMs so that their contents can be inspected.

Top module: `coef_loader_top`

## Requirements
- R1: A bus write is taken once, on the rising edge of `host_wr_n`, when `host_cs_n` is low and `host_rd_n` is high at that edge. The inputs are resynchronised into `clk` first. Addresses 0, 1, 2 and 3 write staging bits 7:0, 15:8, 23:16 and 31:24.
- R2: Writing 0x00 to address 4 copies staging bits 7:0 into the control word, which is visible on `ctrl_word`.
- R3: Writes to address 4 with any value other than 0x00 or 0x0F have no effect. So do writes to addresses 5 to 7, and writes made while `host_cs_n` is high. None of them changes the control word or any RAM.
- R4: With control bit 4 clear (coefficient mode, for example 0x0C), writing 0x0F to address 4 fires an update strobe. Strobes 1, 2 and 3 of a sequence load staging bits 23:0 into word bits 23:0, 47:24 and 71:48. The third strobe writes the 72-bit word into both coefficient RAMs, and the next strobe starts a new sequence.
- R5: With control bit 7 clear, the write address is staging bits 31:24 at the strobe that writes the RAM.
- R6: With control bit 4 set (map mode, for example 0x10), each update strobe writes staging bits 23:16 to the map RAM and leaves the coefficient RAMs unchanged.
- R7: With control bit 7 set (auto-increment), staging bits 31:24 are ignored. The address starts at 0 and rises by one after each completed RAM write, in either mode.
- R8: Every control-word write returns the auto-increment address and the word-slice position to 0, so a partly loaded coefficient word is discarded.
- R9: After reset the control word is 0x00, which selects coefficient mode without auto-increment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_cs_n | input | 1 | Host chip-enable, active low |
| host_rd_n | input | 1 | Host read strobe, active low; a write needs it high |
| host_wr_n | input | 1 | Host write strobe, active low; acts on its rising edge |
| host_addr | input | 3 | Host register address |
| host_data | input | 8 | Host write data |
| ctrl_word | output | 8 | Current control word |
| coef_rd_addr | input | 8 | Test read address for both coefficient RAMs |
| coef_i_rd_data | output | 72 | In-phase coefficient RAM word at `coef_rd_addr` |
| coef_q_rd_data | output | 72 | Quadrature coefficient RAM word at `coef_rd_addr` |
| map_rd_addr | input | 8 | Test read address for the map RAM |
| map_rd_data | output | 8 | Map RAM byte at `map_rd_addr` |

## Verification
On the third coefficient strobe with auto-increment on, three things happen in one clock edge: the RAM commit, the clearing of the slice position, and the address increment. The bench provokes this by loading two coefficient words back to back in auto-increment mode while the top staging byte holds a decoy address. The result is judged by reading the first word at address 0 and the second at address 1, each with correctly ordered slices. The same edge also occurs for map writes, where every strobe both writes and advances the address. Three consecutive bytes must land at addresses 0, 1 and 2.

// File: rtl/loader_pkg.sv
// Shared constants and types of the coefficient RAM loader.
// Assumes a byte-wide host bus; widths of the memories come from module parameters.
package loader_pkg;
    localparam int unsigned HOST_AW     = 3;
    localparam int unsigned HOST_DW     = 8;
    localparam int unsigned STAGE_BYTES = 4;
    localparam int unsigned STAGE_W     = STAGE_BYTES * HOST_DW;
    localparam logic [HOST_AW-1:0] CMD_ADDR  = 3'd4;
    localparam logic [HOST_DW-1:0] CMD_CTRL  = 8'h00;
    localparam logic [HOST_DW-1:0] CMD_STROBE = 8'h0F;
    localparam int unsigned CW_MAP_BIT  = 4;
    localparam int unsigned CW_AUTO_BIT = 7;

    typedef struct packed {
        logic [HOST_AW-1:0] addr;
        logic [HOST_DW-1:0] data;
    } bus_evt_t;
endpackage

// File: rtl/host_sync.sv
// Resynchronises the asynchronous host strobes into clk and emits one
// single-cycle event per completed write (rising edge of wr_n with cs_n low,
// rd_n high). Assumes address and data stay stable around the strobe edge.
module host_sync
    import loader_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cs_n,
    input  logic               rd_n,
    input  logic               wr_n,
    input  logic [HOST_AW-1:0] addr,
    input  logic [HOST_DW-1:0] data,
    output logic               evt_valid,
    output bus_evt_t           evt
);
    logic [2:0] wr_s;
    logic [1:0] cs_s;
    logic [1:0] rd_s;
    bus_evt_t   bus_s0, bus_s1;

    // Two-stage synchronisers plus an edge-detect stage on the write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_s   <= '1;
            cs_s   <= '1;
            rd_s   <= '1;
            bus_s0 <= '0;
            bus_s1 <= '0;
        end else begin
            wr_s   <= {wr_s[1:0], wr_n};
            cs_s   <= {cs_s[0], cs_n};
            rd_s   <= {rd_s[0], rd_n};
            bus_s0 <= '{addr: addr, data: data};
            bus_s1 <= bus_s0;
        end
    end

    // Event on a synchronised low-to-high strobe while selected and not reading.
    always_comb begin
        evt_valid = wr_s[1] & ~wr_s[2] & ~cs_s[1] & rd_s[1];
        evt       = bus_s1;
    end

    a_r1_single_event: assert property (@(posedge clk) disable iff (!rst_n)
        evt_valid |=> !evt_valid);
endmodule

// File: rtl/stage_cmd.sv
// Staging register and command decoder. Byte addresses fill the staging
// register; the command address either loads the control word or raises
// a one-cycle update strobe. Unknown commands are dropped.
module stage_cmd
    import loader_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               evt_valid,
    input  bus_evt_t           evt,
    output logic [STAGE_W-1:0] stage,
    output logic [HOST_DW-1:0] ctrl_word,
    output logic               ctrl_wr,
    output logic               upd_stb
);
    logic is_byte, is_cmd;

    // Classify the event address.
    always_comb begin
        is_byte = evt_valid && (evt.addr < HOST_AW'(STAGE_BYTES));
        is_cmd  = evt_valid && (evt.addr == CMD_ADDR);
    end

    // Staging bytes, control word and command pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage     <= '0;
            ctrl_word <= '0;
            ctrl_wr   <= 1'b0;
            upd_stb   <= 1'b0;
        end else begin
            ctrl_wr <= 1'b0;
            upd_stb <= 1'b0;
            if (is_byte) begin
                stage[evt.addr[1:0]*HOST_DW +: HOST_DW] <= evt.data;
            end
            if (is_cmd && evt.data == CMD_CTRL) begin
                ctrl_word <= stage[HOST_DW-1:0];
                ctrl_wr   <= 1'b1;
            end
            if (is_cmd && evt.data == CMD_STROBE) begin
                upd_stb <= 1'b1;
            end
        end
    end

    a_r2_ctrl_copy: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr |-> ctrl_word == stage[HOST_DW-1:0]);
    a_r3_unknown_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        (is_cmd && evt.data != CMD_CTRL && evt.data != CMD_STROBE)
        |=> ($stable(ctrl_word) && !ctrl_wr && !upd_stb));
    a_r3_one_action: assert property (@(posedge clk) disable iff (!rst_n)
        !(ctrl_wr && upd_stb));
endmodule

// File: rtl/mem_engine.sv
// Word assembly and RAM write engine. In coefficient mode a slice counter
// places each staged slice into the word buffer and the last slice commits
// the word to every coefficient lane; in map mode each strobe writes a byte.
// An optional auto-increment address replaces the staged address.
// RAM contents are not reset.
module mem_engine
    import loader_pkg::*;
#(
    parameter int unsigned ADDR_W  = 8,
    parameter int unsigned SLICE_W = 24,
    parameter int unsigned SLICES  = 3,
    parameter int unsigned MAP_W   = 8,
    parameter int unsigned LANES   = 2,
    localparam int unsigned WORD_W = SLICE_W * SLICES,
    localparam int unsigned DEPTH  = 1 << ADDR_W,
    localparam int unsigned SEL_W  = $clog2(SLICES)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [HOST_DW-1:0]           ctrl_word,
    input  logic                         ctrl_wr,
    input  logic                         upd_stb,
    input  logic [STAGE_W-1:0]           stage,
    input  logic [ADDR_W-1:0]            coef_rd_addr,
    output logic [LANES-1:0][WORD_W-1:0] coef_rd_data,
    input  logic [ADDR_W-1:0]            map_rd_addr,
    output logic [MAP_W-1:0]             map_rd_data
);
    localparam logic [SEL_W-1:0] LAST = SEL_W'(SLICES - 1);

    logic [SEL_W-1:0]  sel;
    logic [ADDR_W-1:0] auto_addr;
    logic [WORD_W-1:0] word_buf;
    logic [WORD_W-1:0] commit_word;
    logic [ADDR_W-1:0] tgt_addr;
    logic              coef_mode, auto_en, coef_commit, map_commit;
    logic [MAP_W-1:0]  map_ram [DEPTH];

    // Mode decode, target address and the assembled word with its last slice.
    always_comb begin
        coef_mode   = ~ctrl_word[CW_MAP_BIT];
        auto_en     = ctrl_word[CW_AUTO_BIT];
        tgt_addr    = auto_en ? auto_addr : stage[SLICE_W +: ADDR_W];
        coef_commit = upd_stb && coef_mode && (sel == LAST);
        map_commit  = upd_stb && !coef_mode;
        commit_word = word_buf;
        commit_word[(SLICES-1)*SLICE_W +: SLICE_W] = stage[SLICE_W-1:0];
    end

    // Slice counter, word buffer and auto-increment address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel       <= '0;
            auto_addr <= '0;
            word_buf  <= '0;
        end else if (ctrl_wr) begin
            sel       <= '0;
            auto_addr <= '0;
        end else if (upd_stb) begin
            if (coef_mode) begin
                word_buf[sel*SLICE_W +: SLICE_W] <= stage[SLICE_W-1:0];
                sel <= (sel == LAST) ? '0 : sel + 1'b1;
            end
            if (auto_en && (coef_commit || map_commit)) begin
                auto_addr <= auto_addr + 1'b1;
            end
        end
    end

    // One coefficient RAM per lane, all written with the same word.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [WORD_W-1:0] coef_ram [DEPTH];

        // Lane write port.
        always_ff @(posedge clk) begin
            if (coef_commit) coef_ram[tgt_addr] <= commit_word;
        end

        assign coef_rd_data[g] = coef_ram[coef_rd_addr];
    end

    // Map RAM write port.
    always_ff @(posedge clk) begin
        if (map_commit) map_ram[tgt_addr] <= stage[SLICE_W-1 -: MAP_W];
    end

    assign map_rd_data = map_ram[map_rd_addr];

    a_r4_sel_range: assert property (@(posedge clk) disable iff (!rst_n)
        sel <= LAST);
    a_r4_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        coef_commit |=> sel == '0);
    a_r6_map_holds_sel: assert property (@(posedge clk) disable iff (!rst_n)
        map_commit |=> $stable(sel));
    a_r7_advance: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_en && (coef_commit || map_commit))
        |=> auto_addr == $past(auto_addr) + 1'b1);
    a_r8_ctrl_clears: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr |=> (sel == '0 && auto_addr == '0));
endmodule

// File: rtl/coef_loader_top.sv
// Top of the indirect coefficient RAM loader: host resynchroniser, staging
// and command decoder, and the RAM write engine with two coefficient lanes
// (in-phase, quadrature) and one map RAM.
module coef_loader_top
    import loader_pkg::*;
#(
    parameter int unsigned ADDR_W  = 8,
    parameter int unsigned SLICE_W = 24,
    parameter int unsigned SLICES  = 3,
    parameter int unsigned MAP_W   = 8,
    localparam int unsigned WORD_W = SLICE_W * SLICES
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               host_cs_n,
    input  logic               host_rd_n,
    input  logic               host_wr_n,
    input  logic [HOST_AW-1:0] host_addr,
    input  logic [HOST_DW-1:0] host_data,
    output logic [HOST_DW-1:0] ctrl_word,
    input  logic [ADDR_W-1:0]  coef_rd_addr,
    output logic [WORD_W-1:0]  coef_i_rd_data,
    output logic [WORD_W-1:0]  coef_q_rd_data,
    input  logic [ADDR_W-1:0]  map_rd_addr,
    output logic [MAP_W-1:0]   map_rd_data
);
    logic               evt_valid, ctrl_wr, upd_stb;
    bus_evt_t           evt;
    logic [STAGE_W-1:0] stage;
    logic [1:0][WORD_W-1:0] lane_rd;

    host_sync u_sync (
        .clk, .rst_n,
        .cs_n(host_cs_n), .rd_n(host_rd_n), .wr_n(host_wr_n),
        .addr(host_addr), .data(host_data),
        .evt_valid, .evt
    );

    stage_cmd u_cmd (
        .clk, .rst_n, .evt_valid, .evt,
        .stage, .ctrl_word, .ctrl_wr, .upd_stb
    );

    mem_engine #(
        .ADDR_W(ADDR_W), .SLICE_W(SLICE_W), .SLICES(SLICES),
        .MAP_W(MAP_W), .LANES(2)
    ) u_mem (
        .clk, .rst_n, .ctrl_word, .ctrl_wr, .upd_stb, .stage,
        .coef_rd_addr, .coef_rd_data(lane_rd),
        .map_rd_addr, .map_rd_data
    );

    assign coef_i_rd_data = lane_rd[0];
    assign coef_q_rd_data = lane_rd[1];
endmodule

// File: tb/coef_loader_top_tb.sv
`timescale 1ns/1ps
module coef_loader_top_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_cs_n = 1'b1, host_rd_n = 1'b1, host_wr_n = 1'b1;
    logic [2:0]  host_addr = '0;
    logic [7:0]  host_data = '0;
    logic [7:0]  ctrl_word;
    logic [7:0]  coef_rd_addr = '0, map_rd_addr = '0;
    logic [71:0] coef_i_rd_data, coef_q_rd_data;
    logic [7:0]  map_rd_data;

    int checks = 0, errors = 0;
    bit finished = 0;

    typedef struct {
        string       req;
        int          kind;  // 0 ctrl word, 1 coef I, 2 coef Q, 3 map
        logic [7:0]  addr;
        logic [71:0] exp;
    } item_t;
    item_t sb[$];

    always #2.5 clk = ~clk;

    coef_loader_top u_dut (
        .clk, .rst_n, .host_cs_n, .host_rd_n, .host_wr_n, .host_addr, .host_data,
        .ctrl_word, .coef_rd_addr, .coef_i_rd_data, .coef_q_rd_data,
        .map_rd_addr, .map_rd_data
    );

    // Monitor: pops expected items, reads the port, compares.
    initial begin
        forever begin
            @(negedge clk);
            while (sb.size() > 0) begin
                item_t it;
                logic [71:0] act;
                it = sb.pop_front();
                coef_rd_addr = it.addr;
                map_rd_addr  = it.addr;
                #1;
                case (it.kind)
                    0: act = {64'h0, ctrl_word};
                    1: act = coef_i_rd_data;
                    2: act = coef_q_rd_data;
                    default: act = {64'h0, map_rd_data};
                endcase
                checks++;
                if (act !== it.exp) begin
                    errors++;
                    $display("FAIL %s kind %0d addr %h actual %h expected %h",
                             it.req, it.kind, it.addr, act, it.exp);
                end
            end
        end
    end

    task automatic expect_item(string req, int kind, logic [7:0] a, logic [71:0] e);
        sb.push_back('{req: req, kind: kind, addr: a, exp: e});
    endtask

    task automatic drain();
        while (sb.size() > 0) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic bus_wr(logic [2:0] a, logic [7:0] d, bit sel = 1);
        @(negedge clk);
        host_addr = a; host_data = d; host_cs_n = !sel;
        @(negedge clk); host_wr_n = 1'b0;
        repeat (3) @(negedge clk);
        host_wr_n = 1'b1;
        repeat (4) @(negedge clk);
        host_cs_n = 1'b1;
        repeat (6) @(negedge clk);
    endtask

    task automatic stage_all(logic [31:0] v);
        for (int b = 0; b < 4; b++) bus_wr(3'(b), v[b*8 +: 8]);
    endtask

    task automatic set_ctrl(logic [7:0] v);
        bus_wr(3'd0, v);
        bus_wr(3'd4, 8'h00);
    endtask

    task automatic strobe();
        bus_wr(3'd4, 8'h0F);
    endtask

    task automatic load_coef(logic [7:0] a, logic [23:0] s0, logic [23:0] s1, logic [23:0] s2);
        stage_all({a, s0}); strobe();
        stage_all({a, s1}); strobe();
        stage_all({a, s2}); strobe();
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        expect_item("R9 reset ctrl", 0, 8'h00, 72'h00);
        drain();

        // Coefficient mode, explicit address: word lands in both lanes.
        set_ctrl(8'h0C);
        expect_item("R2 ctrl copy", 0, 8'h00, 72'h0C);
        load_coef(8'h05, 24'h112233, 24'h445566, 24'h778899);
        expect_item("R4 R5 coef I", 1, 8'h05, 72'h778899_445566_112233);
        expect_item("R4 coef Q", 2, 8'h05, 72'h778899_445566_112233);
        drain();

        // Known coefficient word at 0x33 before a map write to 0x33.
        load_coef(8'h33, 24'hABCDEF, 24'h010203, 24'hFEDCBA);
        expect_item("R5 coef at 33", 1, 8'h33, 72'hFEDCBA_010203_ABCDEF);
        drain();

        // Map mode: one strobe writes one byte, coefficients untouched.
        set_ctrl(8'h10);
        expect_item("R2 ctrl map", 0, 8'h00, 72'h10);
        stage_all(32'h33_A5_0000);
        strobe();
        expect_item("R6 map byte", 3, 8'h33, 72'hA5);
        expect_item("R6 coef I kept", 1, 8'h33, 72'hFEDCBA_010203_ABCDEF);
        expect_item("R6 coef Q kept", 2, 8'h33, 72'hFEDCBA_010203_ABCDEF);
        drain();

        // Ignored writes: odd command, address 6, unselected command.
        bus_wr(3'd0, 8'h99);
        bus_wr(3'd4, 8'h55);
        bus_wr(3'd6, 8'h00);
        bus_wr(3'd4, 8'h00, 0);
        expect_item("R3 ctrl unchanged", 0, 8'h00, 72'h10);
        stage_all(32'h33_5A_0000);
        bus_wr(3'd4, 8'h0E);
        expect_item("R3 map unchanged", 3, 8'h33, 72'hA5);
        drain();

        // Auto-increment coefficient mode with a decoy staged address.
        set_ctrl(8'h8C);
        expect_item("R7 ctrl auto", 0, 8'h00, 72'h8C);
        load_coef(8'hEE, 24'h000001, 24'h000002, 24'h000003);
        load_coef(8'hEE, 24'hA00001, 24'hA00002, 24'hA00003);
        expect_item("R7 auto word0", 1, 8'h00, 72'h000003_000002_000001);
        expect_item("R7 auto word1", 2, 8'h01, 72'hA00003_A00002_A00001);
        drain();

        // Auto-increment map mode: restart at 0.
        set_ctrl(8'h90);
        for (int k = 0; k < 3; k++) begin
            stage_all({8'hEE, 8'(8'hC0 + k), 16'h0});
            strobe();
        end
        for (int k = 0; k < 3; k++)
            expect_item("R7 R8 auto map", 3, 8'(k), 72'(8'hC0 + k));
        drain();

        // Control write discards a partial coefficient word.
        set_ctrl(8'h0C);
        stage_all(32'h40_DEAD00); strobe();
        set_ctrl(8'h0C);
        load_coef(8'h40, 24'h111111, 24'h222222, 24'h333333);
        expect_item("R8 partial discarded", 1, 8'h40, 72'h333333_222222_111111);
        drain();

        // Read strobe low blocks a write.
        stage_all(32'h41_000000);
        host_rd_n = 1'b0;
        bus_wr(3'd0, 8'h77);
        host_rd_n = 1'b1;
        bus_wr(3'd4, 8'h00);
        expect_item("R1 rd blocks write", 0, 8'h00, 72'h00);
        drain();

        if (!finished) begin
            finished = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule